// File: doc/BRIEF.md
# Video Memory Strobe Timing Generator

This block sits in the master-clock domain of a display subsystem. A graphics drawing engine and a host processor share one display memory, and the block produces the timing strobes that memory needs. It counts the master clock into character cycles of a fixed length. Each cycle starts with a one-clock character tick. Within the cycle, the block opens a row-strobe window and then a column-strobe window one clock later.

The two strobes can be masked. The masks are taken at the boundary of each character cycle and hold for the whole cycle, so a strobe is never cut short. Drawing activity blocks both strobes. A refresh in progress blocks only the column strobe. A low-resolution mode bit, also taken at the cycle boundary, has two effects: it adds one shift/load pulse per character cycle, and it halves the rate of the pixel-enable.

The block has three more outputs:
- A host-slot signal that changes level once per character cycle.
- A display-enable that copies the host-slot signal two master clocks later.
- An active-low drawing enable. It stays inactive when both high address bits are set, because that range is the mapping RAM.

All strobes are active high except the drawing enable.

Top module: `vram_strobe_gen`

## Requirements
- R1: The first clock edge with reset low opens a character cycle. Each character cycle is `DIV` (default 8) master clocks long. `charTick` is high for exactly the first clock of each cycle.
- R2: Let phase p be the count of clocks since the cycle opened, where the tick clock is p=0. `rowStb` is high for phases `ROW_ON` (default 2) up to `DIV-1`, then falls when the next cycle opens.
- R3: `colStb` is high for phases `ROW_ON+1` up to `DIV-1`. It rises one clock after `rowStb`, and the two fall together.
- R4: If `drawActive` is high at the edge that opens a cycle, both `rowStb` and `colStb` stay low for that whole cycle.
- R5: If `refreshActive` is high at the edge that opens a cycle and `drawActive` is low, `colStb` stays low for that cycle while `rowStb` runs as normal.
- R6: A change of `drawActive`, `refreshActive` or `mode320` during a cycle has no effect on `rowStb`, `colStb`, `shiftLoad` or `dotEn` until the next cycle opens.
- R7: If `mode320` is high at the cycle-opening edge, `shiftLoad` is high for exactly phase 1 of that cycle. Otherwise `shiftLoad` stays low for the cycle.
- R8: `dotEn` is high on every clock when the cycle was opened with `mode320` low. When `mode320` was high, `dotEn` is high only on even phases.
- R9: `cpuSlot` resets to 0 and inverts at every edge that opens a cycle. It is therefore high during the first cycle after reset and alternates from there.
- R10: `dispEn` equals the value that `cpuSlot` had two master clocks earlier. Before that history exists, `dispEn` is 0.
- R11: After each edge, `drawEnN` is 0 only if that edge sampled `drawActive` high and `addrHi` (bit 1 = address 17, bit 0 = address 16) not equal to 2'b11. In every other case `drawEnN` is 1.
- R12: Reset is synchronous. After a reset edge, `charTick`, `rowStb`, `colStb`, `shiftLoad`, `dotEn`, `cpuSlot` and `dispEn` are 0 and `drawEnN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mode320 | input | 1 | Low-resolution mode select, sampled at cycle start |
| drawActive | input | 1 | Drawing engine is accessing memory |
| refreshActive | input | 1 | Memory refresh in progress |
| addrHi | input | 2 | Address bits 17 (bit 1) and 16 (bit 0) |
| charTick | output | 1 | One-clock pulse opening each character cycle |
| rowStb | output | 1 | Row address strobe, active high |
| colStb | output | 1 | Column address strobe, active high |
| shiftLoad | output | 1 | Extra shift/load pulse in low-resolution mode |
| dotEn | output | 1 | Pixel-rate enable |
| cpuSlot | output | 1 | Host access slot level |
| dispEn | output | 1 | Display enable, host slot delayed by two clocks |
| drawEnN | output | 1 | Drawing enable, active low |

## Verification
The assertions assume that reset is held for at least one clock edge before the first check. They also assume the inputs are sampled only on rising edges, so a mask or mode change inside a cycle may arrive on any clock. The stimulus drives every input at the falling edge. It picks new values either on every clock or at chosen phases, so mask and mode changes fall both on cycle boundaries and inside cycles. It also sweeps all four `addrHi` codes with drawing active and with drawing idle, and applies a reset in the middle of a run.

// File: rtl/vram_tg_pkg.sv
package vram_tg_pkg;

  // Phase windows handed from the cycle counter to the strobe datapath.
  typedef struct packed {
    logic running;     // at least one clock since reset
    logic cycleStart;  // next edge opens a new character cycle
    logic tick;        // current clock is phase 0
    logic rowWin;      // phase is inside the row strobe window
    logic colWin;      // phase is inside the column strobe window
    logic slWin;       // phase carries the shift/load pulse
    logic dotEven;     // phase is even
  } ctlStrobes_t;

endpackage

// File: rtl/vram_tg_ctrl.sv
module vram_tg_ctrl
  import vram_tg_pkg::*;
#(
  parameter int DIV      = 8,
  parameter int ROW_ON   = 2,
  parameter int COL_GAP  = 1,
  parameter int SL_PHASE = 1
) (
  input  logic        clk,
  input  logic        rst,
  output ctlStrobes_t ctl
);

  localparam int CW     = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int COL_ON = ROW_ON + COL_GAP;
  localparam logic [CW-1:0] LAST     = CW'(DIV - 1);
  localparam logic [CW-1:0] ROW_P    = CW'(ROW_ON);
  localparam logic [CW-1:0] COL_P    = CW'(COL_ON);
  localparam logic [CW-1:0] SL_P     = CW'(SL_PHASE);

  logic [CW-1:0] phase;
  logic          running;

  // Reset parks the counter on the last phase so the first live edge opens a cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= LAST;
      running <= 1'b0;
    end else begin
      phase   <= (phase == LAST) ? '0 : phase + 1'b1;
      running <= 1'b1;
    end
  end

  always_comb begin
    ctl.running    = running;
    ctl.cycleStart = (phase == LAST);
    ctl.tick       = (phase == '0);
    ctl.rowWin     = (phase >= ROW_P);
    ctl.colWin     = (phase >= COL_P);
    ctl.slWin      = (phase == SL_P);
    ctl.dotEven    = ~phase[0];
  end

endmodule

// File: rtl/vram_tg_dpath.sv
module vram_tg_dpath
  import vram_tg_pkg::*;
#(
  parameter int DISP_DLY = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  ctlStrobes_t ctl,
  input  logic        mode320,
  input  logic        drawActive,
  input  logic        refreshActive,
  input  logic [1:0]  addrHi,
  output logic        charTick,
  output logic        rowStb,
  output logic        colStb,
  output logic        shiftLoad,
  output logic        dotEn,
  output logic        cpuSlot,
  output logic        dispEn,
  output logic        drawEnN
);

  logic maskRow, maskCol, modeLat, slotQ, drawEnQ;
  logic mapWindow;

  assign mapWindow = &addrHi;

  // Masks and mode are captured once per character cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      maskRow <= 1'b1;
      maskCol <= 1'b1;
      modeLat <= 1'b0;
      slotQ   <= 1'b0;
      drawEnQ <= 1'b1;
    end else begin
      if (ctl.cycleStart) begin
        maskRow <= drawActive;
        maskCol <= drawActive | refreshActive;
        modeLat <= mode320;
        slotQ   <= ~slotQ;
      end
      drawEnQ <= ~(drawActive & ~mapWindow);
    end
  end

  // Display enable: host slot through a parameterised delay line.
  generate
    if (DISP_DLY == 0) begin : g_nodly
      assign dispEn = slotQ;
    end else if (DISP_DLY == 1) begin : g_dly1
      logic dlyQ;
      always_ff @(posedge clk) begin
        if (rst) dlyQ <= 1'b0;
        else     dlyQ <= slotQ;
      end
      assign dispEn = dlyQ;
    end else begin : g_dlyn
      logic [DISP_DLY-1:0] dlyQ;
      always_ff @(posedge clk) begin
        if (rst) dlyQ <= '0;
        else     dlyQ <= {dlyQ[DISP_DLY-2:0], slotQ};
      end
      assign dispEn = dlyQ[DISP_DLY-1];
    end
  endgenerate

  always_comb begin
    charTick  = ctl.running & ctl.tick;
    rowStb    = ctl.running & ctl.rowWin & ~maskRow;
    colStb    = ctl.running & ctl.colWin & ~maskCol;
    shiftLoad = ctl.running & ctl.slWin & modeLat;
    dotEn     = ctl.running & (~modeLat | ctl.dotEven);
    cpuSlot   = slotQ;
    drawEnN   = drawEnQ;
  end

endmodule

// File: rtl/vram_strobe_gen.sv
module vram_strobe_gen
  import vram_tg_pkg::*;
#(
  parameter int DIV      = 8,
  parameter int ROW_ON   = 2,
  parameter int COL_GAP  = 1,
  parameter int SL_PHASE = 1,
  parameter int DISP_DLY = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode320,
  input  logic       drawActive,
  input  logic       refreshActive,
  input  logic [1:0] addrHi,
  output logic       charTick,
  output logic       rowStb,
  output logic       colStb,
  output logic       shiftLoad,
  output logic       dotEn,
  output logic       cpuSlot,
  output logic       dispEn,
  output logic       drawEnN
);

  ctlStrobes_t ctl;

  vram_tg_ctrl #(
    .DIV(DIV), .ROW_ON(ROW_ON), .COL_GAP(COL_GAP), .SL_PHASE(SL_PHASE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .ctl(ctl)
  );

  vram_tg_dpath #(.DISP_DLY(DISP_DLY)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl),
    .mode320(mode320), .drawActive(drawActive), .refreshActive(refreshActive),
    .addrHi(addrHi),
    .charTick(charTick), .rowStb(rowStb), .colStb(colStb), .shiftLoad(shiftLoad),
    .dotEn(dotEn), .cpuSlot(cpuSlot), .dispEn(dispEn), .drawEnN(drawEnN)
  );

endmodule

// File: rtl/vram_strobe_chk.sv
module vram_strobe_chk (
  input logic       clk,
  input logic       rst,
  input logic       drawActive,
  input logic [1:0] addrHi,
  input logic       charTick,
  input logic       rowStb,
  input logic       colStb,
  input logic       shiftLoad,
  input logic       dotEn,
  input logic       cpuSlot,
  input logic       dispEn,
  input logic       drawEnN
);

  logic [1:0] sinceRst;
  logic       seenRst;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= 2'd0;
      seenRst  <= 1'b1;
    end else if (sinceRst != 2'd3) begin
      sinceRst <= sinceRst + 2'd1;
    end
  end

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    charTick |=> !charTick);

  // R3
  col_in_row_chk: assert property (@(posedge clk) disable iff (rst)
    colStb |-> rowStb);

  // R6
  row_no_trunc_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3 && $fell(rowStb)) |-> charTick);

  // R7
  sl_single_chk: assert property (@(posedge clk) disable iff (rst)
    shiftLoad |=> !shiftLoad);

  // R9
  slot_at_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3 && cpuSlot != $past(cpuSlot)) |-> charTick);

  // R10
  disp_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3) |-> (dispEn == $past(cpuSlot, 2)));

  // R11
  map_block_chk: assert property (@(posedge clk) disable iff (rst)
    (drawActive && addrHi == 2'b11) |=> drawEnN);

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    (seenRst && rst) |=> (!charTick && !rowStb && !colStb && !shiftLoad &&
                          !dotEn && !cpuSlot && !dispEn && drawEnN));

endmodule

bind vram_strobe_gen vram_strobe_chk u_chk (
  .clk(clk), .rst(rst), .drawActive(drawActive), .addrHi(addrHi),
  .charTick(charTick), .rowStb(rowStb), .colStb(colStb), .shiftLoad(shiftLoad),
  .dotEn(dotEn), .cpuSlot(cpuSlot), .dispEn(dispEn), .drawEnN(drawEnN)
);

// File: tb/tb_vram_strobe_gen.sv
module tb_vram_strobe_gen;

  localparam int DIV = 8;
  localparam int ROW_ON = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode320 = 1'b0, drawActive = 1'b0, refreshActive = 1'b0;
  logic [1:0] addrHi = 2'b00;
  logic charTick, rowStb, colStb, shiftLoad, dotEn, cpuSlot, dispEn, drawEnN;

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;

  // Bench model state, from the requirements.
  int  k = 0;                 // live edges since reset
  logic eMaskR = 1, eMaskC = 1, eMode = 0, eDrawN = 1;
  logic slotHist[3];          // cpuSlot after edges k, k-1, k-2

  always #10 clk = ~clk;      // 50 MHz

  vram_strobe_gen dut (
    .clk(clk), .rst(rst), .mode320(mode320), .drawActive(drawActive),
    .refreshActive(refreshActive), .addrHi(addrHi),
    .charTick(charTick), .rowStb(rowStb), .colStb(colStb), .shiftLoad(shiftLoad),
    .dotEn(dotEn), .cpuSlot(cpuSlot), .dispEn(dispEn), .drawEnN(drawEnN)
  );

  function automatic int phaseOf(int edges);
    return (edges - 1) % DIV;
  endfunction

  function automatic logic slotOf(int edges);
    if (edges < 1) return 1'b0;
    return (((edges - 1) / DIV) % 2) == 0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      k = 0;
      eMaskR = 1; eMaskC = 1; eMode = 0; eDrawN = 1;
    end else begin
      k = k + 1;
      if (phaseOf(k) == 0) begin
        eMaskR = drawActive;
        eMaskC = drawActive | refreshActive;
        eMode  = mode320;
      end
      eDrawN = !(drawActive && addrHi != 2'b11);
    end
  end

  task automatic cmp(input logic act, input logic exp, input string req, input string name);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s at edge %0d: got %b expected %b", req, name, k, act, exp);
    end
  endtask

  task automatic checkAll();
    int p;
    if (k == 0) begin
      cmp(charTick, 0, "R12", "charTick");
      cmp(rowStb, 0, "R12", "rowStb");
      cmp(colStb, 0, "R12", "colStb");
      cmp(shiftLoad, 0, "R12", "shiftLoad");
      cmp(dotEn, 0, "R12", "dotEn");
      cmp(cpuSlot, 0, "R12", "cpuSlot");
      cmp(dispEn, 0, "R12", "dispEn");
      cmp(drawEnN, 1, "R12", "drawEnN");
      return;
    end
    p = phaseOf(k);
    cmp(charTick, p == 0, "R1", "charTick");
    cmp(rowStb, !eMaskR && p >= ROW_ON, "R2/R4/R6", "rowStb");
    cmp(colStb, !eMaskC && p >= ROW_ON + 1, "R3/R5/R6", "colStb");
    cmp(shiftLoad, eMode && p == 1, "R7", "shiftLoad");
    cmp(dotEn, !eMode || (p % 2 == 0), "R8", "dotEn");
    cmp(cpuSlot, slotOf(k), "R9", "cpuSlot");
    cmp(dispEn, slotOf(k - 2), "R10", "dispEn");
    cmp(drawEnN, eDrawN, "R11", "drawEnN");
  endtask

  // One clock: sample at the falling edge, then drive new inputs.
  task automatic step(input logic m, input logic d, input logic r, input logic [1:0] a);
    @(negedge clk);
    checkAll();
    mode320 = m; drawActive = d; refreshActive = r; addrHi = a;
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); checkAll();          // R12 reset state
    rst = 0;
    // R1 R2 R3: 640 mode, no masks
    repeat (4 * DIV) step(0, 0, 0, 2'b00);
    // R7 R8: low-resolution mode
    repeat (4 * DIV) step(1, 0, 0, 2'b00);
    // R4: drawing mask across whole cycles
    repeat (2 * DIV) step(0, 1, 0, 2'b01);
    // R5: refresh mask only
    repeat (2 * DIV) step(0, 0, 1, 2'b00);
    // R6: toggle inputs mid-cycle
    for (int i = 0; i < 6 * DIV; i++)
      step((i % DIV) == 4, (i % DIV) == 3, (i % DIV) >= 5, 2'b00);
    // R11: all address codes with drawing on and off
    for (int i = 0; i < 8; i++) step(0, i[2], 0, i[1:0]);
    // Random mix
    for (int i = 0; i < 1500; i++)
      step($urandom_range(0, 1), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)));
    // R12: reset in the middle of a run
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    checkAll();
    rst = 0;
    for (int i = 0; i < 300; i++)
      step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           2'($urandom_range(0, 3)));
    @(negedge clk); checkAll();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule